// File: doc/BRIEF.md
# Banked Scratchpad With Per-Bank Conflict Serialization

This block is a 16 KB on-chip scratchpad split into 16 independent banks, each one 32-bit word wide. A group of 16 requesters is handed to it together. Each requester carries an active flag, a word address, a write flag and write data. The block works out which bank each address falls into and finds the banks that are asked for more than one distinct word. It then spreads the group over exactly as many cycles as the worst bank needs, and returns one read word per requester with a single done pulse.

Requesters that name the same word are merged into one bank access, so a word read by many requesters costs one cycle. Only requesters inside one group are compared. A group is accepted with a one-cycle start strobe while the block is idle. Until the done pulse the block reports busy and ignores further start strobes.

Top module: `shm_banked_top`

## Requirements
- R1: After a synchronous reset, busy and done are low and every read-data lane is zero.
- R2: A word address A (12 bits, 4096 words) lives in bank A mod 16 at row A div 16. A word written by one group is returned to any later group reading A.
- R3: When every active requester of a group falls into a different bank, the group takes one service cycle. Done is high in the second cycle after the cycle in which start was sampled.
- R4: When all requesters name one word, it is read once and its value is returned on every lane in one service cycle.
- R5: The number of service cycles K equals the largest count of distinct addresses that map to a single bank. Done rises K+1 cycles after the start sample. Stride 2 gives K=2, stride 8 gives K=8, and any odd stride gives K=1.
- R6: Every read in a group returns the memory contents from before that group, even when a requester in the same group writes that word.
- R7: When several requesters of one group write the same word, the data of the highest-numbered writer is stored.
- R8: Busy is high from the cycle after an accepted start until done. A start strobe while busy is ignored: it neither changes memory nor starts a group.
- R9: Done is a one-cycle pulse. The read-data lanes are valid with it and hold their values until the next group is accepted.
- R10: Inactive requesters cause no access, add nothing to K and return zero on their lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe for a group, taken only when idle |
| req_act | input | 16 | Active flag per requester |
| req_addr | input | 16*12 | Word address per requester, lane i at bits [12i+11:12i] |
| req_we | input | 16 | Write flag per requester |
| req_wdata | input | 16*32 | Write data per requester, lane i at bits [32i+31:32i] |
| busy | output | 1 | High while a group is in service |
| done | output | 1 | One-cycle pulse when a group is finished |
| rd_data | output | 16*32 | Read data per requester, lane i at bits [32i+31:32i] |

## Verification
The hardest state to reach is a mixed group in which one bank holds several distinct words and several requesters share one of them, some writing and some reading. Only then do merging, read-before-write ordering and highest-writer selection all happen in the same cycle. The bench first fills the whole memory with an address-derived pattern. It then sweeps every stride from 1 to 16 and builds hand-made same-word mixes of readers and writers. Last, it runs random groups confined to 64 words, so that conflicts and shared words come up often. For every group it computes the service-cycle count and the lane values from its own model. A start strobe during a long stride-8 group shows that a busy block ignores start.

// File: rtl/shm_pkg.sv
package shm_pkg;
  localparam int unsigned SHM_NREQ  = 16;
  localparam int unsigned SHM_NBANK = 16;
  localparam int unsigned SHM_DW    = 32;
  localparam int unsigned SHM_WORDS = 4096;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_FIN   = 2'd2
  } shm_state_e;
endpackage

// File: rtl/shm_bank.sv
module shm_bank #(
  parameter int unsigned DW   = 32,
  parameter int unsigned ROWS = 256,
  localparam int unsigned RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd
);
  logic [DW-1:0] mem [ROWS];

  // read-first single port, suited to block RAM inference
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wd;
      rd <= mem[row];
    end
  end
endmodule

// File: rtl/shm_sched.sv
module shm_sched #(
  parameter int unsigned NREQ  = 16,
  parameter int unsigned NBANK = 16,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned RW   = AW - BW
) (
  input  logic [NREQ-1:0]     pend,
  input  logic [NREQ*AW-1:0]  addr,
  input  logic [NREQ-1:0]     we,
  input  logic [NREQ*DW-1:0]  wdata,
  output logic [NREQ-1:0]     served,
  output logic [NBANK-1:0]    bank_en,
  output logic [NBANK-1:0]    bank_we,
  output logic [NBANK*RW-1:0] bank_row,
  output logic [NBANK*DW-1:0] bank_wd
);
  logic [NBANK-1:0][NREQ-1:0] mtab;

  for (genvar b = 0; b < NBANK; b++) begin : gb
    logic          found;
    logic [AW-1:0] lead;
    logic [NREQ-1:0] m;
    logic          wr;
    logic [DW-1:0] wd;

    always_comb begin
      found = 1'b0;
      lead  = '0;
      // lowest-numbered pending requester of this bank leads
      for (int i = 0; i < NREQ; i++) begin
        if (!found && pend[i] && (addr[i*AW +: BW] == BW'(b))) begin
          found = 1'b1;
          lead  = addr[i*AW +: AW];
        end
      end
      m  = '0;
      wr = 1'b0;
      wd = '0;
      // every pending requester on the same word rides along;
      // the last writer in index order wins
      for (int i = 0; i < NREQ; i++) begin
        if (found && pend[i] && (addr[i*AW +: AW] == lead)) begin
          m[i] = 1'b1;
          if (we[i]) begin
            wr = 1'b1;
            wd = wdata[i*DW +: DW];
          end
        end
      end
    end

    assign mtab[b]             = m;
    assign bank_en[b]          = found;
    assign bank_we[b]          = wr;
    assign bank_row[b*RW +: RW] = lead[AW-1:BW];
    assign bank_wd[b*DW +: DW]  = wd;
  end

  always_comb begin
    served = '0;
    for (int b = 0; b < NBANK; b++) served |= mtab[b];
  end
endmodule

// File: rtl/shm_banked_top.sv
module shm_banked_top
  import shm_pkg::*;
#(
  parameter int unsigned NREQ  = SHM_NREQ,
  parameter int unsigned NBANK = SHM_NBANK,
  parameter int unsigned DW    = SHM_DW,
  parameter int unsigned WORDS = SHM_WORDS,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned RW   = AW - BW,
  localparam int unsigned ROWS = WORDS / NBANK
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NREQ-1:0]    req_act,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ-1:0]    req_we,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic               busy,
  output logic               done,
  output logic [NREQ*DW-1:0] rd_data
);
  shm_state_e state;

  logic [NREQ-1:0]          pend_q;
  logic [NREQ-1:0][AW-1:0]  addr_q;
  logic [NREQ-1:0]          we_q;
  logic [NREQ-1:0][DW-1:0]  wd_q;
  logic [NREQ-1:0]          served_q;
  logic [NREQ-1:0][DW-1:0]  rd_q;
  logic                     done_q;

  logic [NREQ-1:0]    pend_act;
  logic [NREQ-1:0]    served;
  logic [NREQ-1:0]    remain;
  logic [NBANK-1:0]   bank_en;
  logic [NBANK-1:0]   bank_we;
  logic [NBANK*RW-1:0] bank_row;
  logic [NBANK*DW-1:0] bank_wd;
  logic [DW-1:0]      bank_rd [NBANK];

  assign pend_act = (state == ST_SERVE) ? pend_q : '0;
  assign remain   = pend_q & ~served;

  shm_sched #(
    .NREQ (NREQ),
    .NBANK(NBANK),
    .AW   (AW),
    .DW   (DW)
  ) u_sched (
    .pend    (pend_act),
    .addr    (addr_q),
    .we      (we_q),
    .wdata   (wd_q),
    .served  (served),
    .bank_en (bank_en),
    .bank_we (bank_we),
    .bank_row(bank_row),
    .bank_wd (bank_wd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : gbank
    shm_bank #(
      .DW  (DW),
      .ROWS(ROWS)
    ) u_bank (
      .clk(clk),
      .en (bank_en[b]),
      .we (bank_we[b]),
      .row(bank_row[b*RW +: RW]),
      .wd (bank_wd[b*DW +: DW]),
      .rd (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pend_q   <= '0;
      addr_q   <= '0;
      we_q     <= '0;
      wd_q     <= '0;
      served_q <= '0;
      rd_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      served_q <= '0;
      done_q   <= (state == ST_FIN);
      // lanes served in the previous cycle pick up their bank output
      for (int i = 0; i < NREQ; i++) begin
        if (served_q[i]) rd_q[i] <= bank_rd[addr_q[i][BW-1:0]];
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SERVE;
            pend_q <= req_act;
            addr_q <= req_addr;
            we_q   <= req_we;
            wd_q   <= req_wdata;
            rd_q   <= '0;
          end
        end
        ST_SERVE: begin
          pend_q   <= remain;
          served_q <= served;
          if (remain == '0) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/shm_checker.sv
module shm_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done
);
  // R8: an idle block takes a start and turns busy
  a_r8_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R8: busy is released together with done
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9: done lasts one cycle
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done only follows a cycle spent busy
  a_r9_from_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !done);
endmodule

bind shm_banked_top shm_checker u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .busy (busy),
  .done (done)
);

// File: tb/shm_banked_top_test.sv
module shm_banked_top_test;
  localparam int N  = 16;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N-1:0]    req_act = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    req_we = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic            busy;
  logic            done;
  logic [N*DW-1:0] rd_data;

  shm_banked_top uut (
    .clk(clk), .rst(rst), .start(start),
    .req_act(req_act), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] model [4096];
  logic          act [N];
  logic          wen [N];
  logic [AW-1:0] ad  [N];
  logic [DW-1:0] wdt [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint actv, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actv, expv);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return (DW'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  task automatic run_group(input string ltag, input string dtag, input bit inj);
    int k;
    int cyc;
    int bad;
    logic [DW-1:0] exp_rd [N];
    // expected service cycles: worst distinct-address count over banks
    k = 0;
    for (int b = 0; b < 16; b++) begin
      int cnt = 0;
      for (int i = 0; i < N; i++) begin
        if (act[i] && (int'(ad[i]) % 16 == b)) begin
          bit dup = 1'b0;
          for (int j = 0; j < i; j++)
            if (act[j] && ad[j] == ad[i]) dup = 1'b1;
          if (!dup) cnt++;
        end
      end
      if (cnt > k) k = cnt;
    end
    for (int i = 0; i < N; i++) exp_rd[i] = act[i] ? model[ad[i]] : '0;
    for (int i = 0; i < N; i++) if (act[i] && wen[i]) model[ad[i]] = wdt[i];

    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      req_act[i] = act[i];
      req_we[i]  = wen[i];
      req_addr[i*AW +: AW]  = ad[i];
      req_wdata[i*DW +: DW] = wdt[i];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    if (inj) begin
      chk(busy == 1'b1, "R8", "busy after accept", longint'(busy), 1);
      req_act = '1;
      req_we  = '1;
      for (int i = 0; i < N; i++) begin
        req_addr[i*AW +: AW]  = AW'(i);
        req_wdata[i*DW +: DW] = 32'hDEADBEEF;
      end
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == k + 1, ltag, "latency", longint'(cyc), longint'(k + 1));
    bad = 0;
    for (int i = 0; i < N; i++) begin
      if (rd_data[i*DW +: DW] !== exp_rd[i]) begin
        if (bad == 0)
          chk(1'b0, dtag, $sformatf("lane %0d", i),
              longint'(rd_data[i*DW +: DW]), longint'(exp_rd[i]));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, dtag, "lanes", 0, 0);
  endtask

  task automatic clear_req();
    for (int i = 0; i < N; i++) begin
      act[i] = 1'b0; wen[i] = 1'b0; ad[i] = '0; wdt[i] = '0;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [N*DW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1", "busy after reset", longint'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", longint'(done), 0);
    chk(rd_data == '0, "R1", "rd_data after reset", 0, 0);

    // R3 / R2: fill every word, one conflict-free group per 16 words
    for (int g = 0; g < 256; g++) begin
      for (int i = 0; i < N; i++) begin
        act[i] = 1'b1; wen[i] = 1'b1;
        ad[i]  = AW'(g * 16 + i);
        wdt[i] = pat(g * 16 + i);
      end
      run_group("R3", "R10", 1'b0);
    end

    // R5 / R2: every stride from 1 to 16 from an odd base
    for (int s = 1; s <= 16; s++) begin
      for (int i = 0; i < N; i++) begin
        act[i] = 1'b1; wen[i] = 1'b0;
        ad[i]  = AW'((3 + s * i) % 4096);
        wdt[i] = '0;
      end
      run_group("R5", "R2", 1'b0);
    end

    // R4: broadcast of one word
    for (int i = 0; i < N; i++) begin
      act[i] = 1'b1; wen[i] = 1'b0; ad[i] = 12'd77; wdt[i] = '0;
    end
    run_group("R4", "R4", 1'b0);

    // R6 / R7: same word, even lanes read, odd lanes write
    for (int i = 0; i < N; i++) begin
      act[i] = 1'b1; wen[i] = i[0]; ad[i] = 12'd500;
      wdt[i] = DW'(i * 100 + 7);
    end
    run_group("R4", "R6", 1'b0);
    clear_req();
    act[0] = 1'b1; ad[0] = 12'd500;
    run_group("R3", "R7", 1'b0);
    chk(rd_data[DW-1:0] == 32'd1507, "R7", "highest writer kept",
        longint'(rd_data[DW-1:0]), 1507);

    // R10: inactive lanes aim at conflicting words of bank 0
    for (int i = 0; i < N; i++) begin
      act[i] = (i % 2 == 0); wen[i] = 1'b0;
      ad[i]  = act[i] ? AW'(i + 16 * i) : AW'(16 * i);
      wdt[i] = '0;
    end
    run_group("R10", "R10", 1'b0);

    // R5 / R6 / R7: random groups inside 64 words
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < N; i++) begin
        act[i] = ($urandom_range(3) != 0);
        wen[i] = ($urandom_range(1) == 1);
        ad[i]  = AW'($urandom_range(63));
        wdt[i] = $urandom;
      end
      run_group("R5", "R6", 1'b0);
    end

    // R8: start while busy on a stride-8 group is ignored
    for (int i = 0; i < N; i++) begin
      act[i] = 1'b1; wen[i] = 1'b0; ad[i] = AW'(8 * i + 1); wdt[i] = '0;
    end
    run_group("R8", "R8", 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R8", "no extra group",
          longint'({busy, done}), 0);
    end
    for (int i = 0; i < N; i++) begin
      act[i] = 1'b1; wen[i] = 1'b0; ad[i] = AW'(i); wdt[i] = '0;
    end
    run_group("R3", "R8", 1'b0);

    // R9: done pulse width and lane hold
    held = rd_data;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", longint'(done), 0);
    repeat (4) @(negedge clk);
    chk(rd_data == held, "R9", "lanes held", 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule